// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This unit produces the bit clock of a CAN node from a faster local clock. A programmable divider cuts the local clock into time quanta. Each nominal bit is counted out in quanta as four back-to-back segments: a fixed one-quantum sync segment, then propagation, phase 1 and phase 2. The bus value is taken at the end of phase 1. The transmitter is told when each new bit begins.

The receive line is NRZ and carries no clock, so the unit watches it for recessive-to-dominant transitions. It uses them to move its own bit boundary toward the transmitter's. A transition seen while the bus is idle restarts the bit outright (hard synchronization). A transition seen during a frame moves the sample point within a limit, the jump width: it stretches phase 1 when the transition is late and trims phase 2 when it is early.

The receive line is sampled once per quantum, at the quantum boundary. It must already be synchronous to `clk`. The frame logic drives `bus_idle` to select hard synchronization.

Top module: `can_bit_timing`

## Requirements
- R1: One time quantum lasts `cfg_brp + 1` clock cycles. The first quantum after reset ends at the `cfg_brp + 1`-th rising edge with reset low.
- R2: A bit lasts 1 + (`cfg_prop`+1) + (`cfg_ph1`+1) + (`cfg_ph2`+1) quanta, with the four segments in the order sync, propagation, phase 1, phase 2. Each segment field holds its length minus one. `bit_start_stb` is high for one clock on every entry into the sync segment.
- R3: `sample_stb` is high for one clock as phase 1 ends. `sample_bit` carries the value of `rx` at that quantum boundary.
- R4: During reset `bit_start_stb` and `sample_stb` are 0, `sample_bit` is 1 (recessive), and the first quantum after reset is a sync quantum.
- R5: A falling edge of `rx` (1 = recessive, 0 = dominant) is located in the quantum at whose end it is first seen. If that quantum is the k-th after the sync quantum and lies in propagation or phase 1, phase 1 is lengthened by min(k, `cfg_sjw`+1) quanta.
- R6: A falling edge located in phase-2 quantum c (counting from 0) shortens phase 2 by min(L2 - 1 - c, `cfg_sjw`+1), where L2 is the phase-2 length. The next sync quantum then follows sooner.
- R7: A falling edge located in the sync quantum changes no segment length.
- R8: At most one adjustment is made per bit. After one has been made, further edges are ignored until the next sample strobe.
- R9: While `bus_idle` is 1, a falling edge makes the quantum it is located in the sync quantum. `bit_start_stb` pulses and counting resumes with the first propagation quantum.
- R10: Rising edges of `rx` cause no synchronization of either kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_brp | input | BRP_W | Quantum length in clocks, minus one |
| cfg_prop | input | SEG_W | Propagation segment length minus one |
| cfg_ph1 | input | SEG_W | Phase 1 length minus one |
| cfg_ph2 | input | SEG_W | Phase 2 length minus one (at least 1) |
| cfg_sjw | input | SJW_W | Jump width minus one |
| bus_idle | input | 1 | Selects hard synchronization on the next falling edge |
| rx | input | 1 | Receive line, synchronous to clk |
| bit_start_stb | output | 1 | One-clock pulse as a bit's sync segment begins |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Bus value taken at the last sample point |

## Verification
Both strobes rise in the clock after the rising edge that closes a quantum, so an event at quantum boundary Q is due right after edge Q·(`cfg_brp`+1) counted from reset release. The bench plans each scenario in quanta: nominal strobes, stretched or trimmed bits, and restarts. It converts them to edge numbers and queues them in order. A monitor reads the outputs on the falling clock edge and compares each strobe's edge number and bit value with the head of the queue. Edges on `rx` are driven inside a chosen quantum, so the quantum each edge is located in is known exactly.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
package cbt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/cbt_tq_prescaler.sv
`timescale 1ns/1ps
module cbt_tq_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BRP_W-1:0] cfg_brp,
  output logic             tq_tick
);
  logic [BRP_W-1:0] div_cnt;

  // >= keeps the divider from running away if cfg_brp is lowered mid-count
  assign tq_tick = (div_cnt >= cfg_brp);

  always_ff @(posedge clk) begin
    if (rst)          div_cnt <= '0;
    else if (tq_tick) div_cnt <= '0;
    else              div_cnt <= div_cnt + 1'b1;
  end

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    (tq_tick && $stable(cfg_brp) && cfg_brp != '0) |=> !tq_tick);
endmodule

// File: rtl/cbt_rx_edge.sv
`timescale 1ns/1ps
module cbt_rx_edge (
  input  logic clk,
  input  logic rst,
  input  logic tq_tick,
  input  logic rx,
  output logic rx_fall
);
  logic rx_prev;

  always_ff @(posedge clk) begin
    if (rst)          rx_prev <= 1'b1;
    else if (tq_tick) rx_prev <= rx;
  end

  // only recessive (1) to dominant (0) is used, judged on the quantum grid
  assign rx_fall = tq_tick & rx_prev & ~rx;

  assert_fall_leaves_low_R10: assert property (@(posedge clk) disable iff (rst)
    rx_fall |=> !rx_prev);
endmodule

// File: rtl/cbt_seg_sequencer.sv
`timescale 1ns/1ps
module cbt_seg_sequencer
  import cbt_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tq_tick,
  input  logic             rx_fall,
  input  logic             rx,
  input  logic             bus_idle,
  input  logic [SEG_W-1:0] cfg_prop,
  input  logic [SEG_W-1:0] cfg_ph1,
  input  logic [SEG_W-1:0] cfg_ph2,
  input  logic [SJW_W-1:0] cfg_sjw,
  output logic             bit_start_stb,
  output logic             sample_stb,
  output logic             sample_bit
);
  localparam int LEN_W = SEG_W + 2;
  localparam int JW_W  = SJW_W + 1;

  seg_e             seg, seg_n;
  logic [LEN_W-1:0] cnt, cnt_n;
  logic [JW_W-1:0]  ext, ext_n;
  logic [JW_W-1:0]  cut, cut_n;
  logic             done, done_n;
  logic             start_n, samp_n, sbit_n;
  logic [LEN_W-1:0] prop_len, ph1_len, ph2_len, ph1_eff, ph2_eff;
  logic [JW_W-1:0]  jw;

  assign prop_len = LEN_W'(cfg_prop) + LEN_W'(1);
  assign ph1_len  = LEN_W'(cfg_ph1) + LEN_W'(1);
  assign ph2_len  = LEN_W'(cfg_ph2) + LEN_W'(1);
  assign jw       = JW_W'(cfg_sjw) + JW_W'(1);

  function automatic logic [JW_W-1:0] clip_jw(input logic [LEN_W-1:0] err,
                                              input logic [JW_W-1:0] lim);
    if (err > LEN_W'(lim)) return lim;
    return JW_W'(err);
  endfunction

  always_comb begin
    seg_n   = seg;
    cnt_n   = cnt;
    ext_n   = ext;
    cut_n   = cut;
    done_n  = done;
    start_n = 1'b0;
    samp_n  = 1'b0;
    sbit_n  = sample_bit;
    ph1_eff = ph1_len + LEN_W'(ext);
    ph2_eff = ph2_len - LEN_W'(cut);
    if (tq_tick) begin
      if (bus_idle && rx_fall) begin
        // hard sync: the quantum just ended was the sync quantum
        seg_n   = SEG_PROP;
        cnt_n   = '0;
        ext_n   = '0;
        cut_n   = '0;
        done_n  = 1'b1;
        start_n = 1'b1;
      end else begin
        if (rx_fall && !done && seg != SEG_SYNC) begin
          done_n = 1'b1;
          if (seg == SEG_PH2)
            cut_n = cut + clip_jw(ph2_len - LEN_W'(1) - cnt, jw);
          else if (seg == SEG_PROP)
            ext_n = clip_jw(cnt + LEN_W'(1), jw);
          else
            ext_n = clip_jw(prop_len + cnt + LEN_W'(1), jw);
        end
        ph1_eff = ph1_len + LEN_W'(ext_n);
        ph2_eff = ph2_len - LEN_W'(cut_n);
        case (seg)
          SEG_SYNC: begin
            seg_n = SEG_PROP;
            cnt_n = '0;
          end
          SEG_PROP: begin
            if (cnt == prop_len - LEN_W'(1)) begin
              seg_n = SEG_PH1;
              cnt_n = '0;
            end else cnt_n = cnt + LEN_W'(1);
          end
          SEG_PH1: begin
            if (cnt == ph1_eff - LEN_W'(1)) begin
              seg_n  = SEG_PH2;
              cnt_n  = '0;
              samp_n = 1'b1;
              sbit_n = rx;
              done_n = 1'b0;
              ext_n  = '0;
            end else cnt_n = cnt + LEN_W'(1);
          end
          default: begin
            if (cnt >= ph2_eff - LEN_W'(1)) begin
              seg_n   = SEG_SYNC;
              cnt_n   = '0;
              cut_n   = '0;
              start_n = 1'b1;
            end else cnt_n = cnt + LEN_W'(1);
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg           <= SEG_SYNC;
      cnt           <= '0;
      ext           <= '0;
      cut           <= '0;
      done          <= 1'b0;
      bit_start_stb <= 1'b0;
      sample_stb    <= 1'b0;
      sample_bit    <= 1'b1;
    end else begin
      seg           <= seg_n;
      cnt           <= cnt_n;
      ext           <= ext_n;
      cut           <= cut_n;
      done          <= done_n;
      bit_start_stb <= start_n;
      sample_stb    <= samp_n;
      sample_bit    <= sbit_n;
    end
  end

  assert_sync_one_quantum_R2: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_SYNC) |-> (cnt == '0));
  assert_start_marks_bit_R2: assert property (@(posedge clk) disable iff (rst)
    bit_start_stb |-> (cnt == '0 && (seg == SEG_SYNC || (seg == SEG_PROP && done))));
  assert_sample_enters_ph2_R3: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (seg == SEG_PH2 && cnt == '0 && !done));
  assert_sample_single_R3: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);
  assert_ext_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    ext <= jw);
  assert_ext_held_R8: assert property (@(posedge clk) disable iff (rst)
    (ext != '0 && seg == SEG_PH1 && !tq_tick) |=> (ext == $past(ext)));
  assert_hard_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (tq_tick && bus_idle && rx_fall) |=> (seg == SEG_PROP && cnt == '0 && bit_start_stb));
endmodule

// File: rtl/can_bit_timing.sv
`timescale 1ns/1ps
module can_bit_timing #(
  parameter int BRP_W = 6,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BRP_W-1:0] cfg_brp,
  input  logic [SEG_W-1:0] cfg_prop,
  input  logic [SEG_W-1:0] cfg_ph1,
  input  logic [SEG_W-1:0] cfg_ph2,
  input  logic [SJW_W-1:0] cfg_sjw,
  input  logic             bus_idle,
  input  logic             rx,
  output logic             bit_start_stb,
  output logic             sample_stb,
  output logic             sample_bit
);
  logic tq_tick;
  logic rx_fall;

  cbt_tq_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .cfg_brp (cfg_brp),
    .tq_tick (tq_tick)
  );

  cbt_rx_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .tq_tick (tq_tick),
    .rx      (rx),
    .rx_fall (rx_fall)
  );

  cbt_seg_sequencer #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .tq_tick       (tq_tick),
    .rx_fall       (rx_fall),
    .rx            (rx),
    .bus_idle      (bus_idle),
    .cfg_prop      (cfg_prop),
    .cfg_ph1       (cfg_ph1),
    .cfg_ph2       (cfg_ph2),
    .cfg_sjw       (cfg_sjw),
    .bit_start_stb (bit_start_stb),
    .sample_stb    (sample_stb),
    .sample_bit    (sample_bit)
  );

  assert_strobes_apart_R2: assert property (@(posedge clk) disable iff (rst)
    !(bit_start_stb && sample_stb));
endmodule

// File: tb/can_bit_timing_bench.sv
`timescale 1ns/1ps
module can_bit_timing_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cfg_brp = '0;
  logic [2:0] cfg_prop = '0, cfg_ph1 = '0, cfg_ph2 = 3'd1;
  logic [1:0] cfg_sjw = '0;
  logic       bus_idle = 1'b0;
  logic       rx = 1'b1;
  logic       bit_start_stb, sample_stb, sample_bit;

  always #2.5 clk = ~clk;

  can_bit_timing u_can_bit_timing (
    .clk(clk), .rst(rst), .cfg_brp(cfg_brp), .cfg_prop(cfg_prop),
    .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw),
    .bus_idle(bus_idle), .rx(rx), .bit_start_stb(bit_start_stb),
    .sample_stb(sample_stb), .sample_bit(sample_bit)
  );

  typedef struct {
    bit    is_sample;
    int    at_q;
    bit    val;
    string req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  int   n_clk = 1;
  int   cyc = 0;
  bit   wd_hit = 0;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input bit is_sample, input int at_q, input bit val, input string req);
    exp_t e;
    e.is_sample = is_sample;
    e.at_q = at_q;
    e.val = val;
    e.req = req;
    q.push_back(e);
  endtask

  // scoreboard monitor: strobes are compared against the queue head
  always @(negedge clk) begin
    if (!rst && (sample_stb || bit_start_stb)) begin
      if (q.size() == 0) begin
        check(1'b0, "R2", "unexpected strobe at edge", cyc, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(sample_stb == e.is_sample, e.req, "strobe kind (1=sample)",
              int'(sample_stb), int'(e.is_sample));
        check(cyc == e.at_q * n_clk, e.req, "strobe edge number", cyc, e.at_q * n_clk);
        if (e.is_sample)
          check(sample_bit == e.val, e.req, "sampled bit", int'(sample_bit), int'(e.val));
      end
    end
  end

  // lengths are given in quanta; fields carry length minus one
  task automatic start_case(input int brp, input int lp, input int l1, input int l2,
                            input int jw, input bit idle, input bit rx0);
    @(negedge clk);
    rst = 1'b1;
    cfg_brp = 6'(brp);
    cfg_prop = 3'(lp - 1);
    cfg_ph1 = 3'(l1 - 1);
    cfg_ph2 = 3'(l2 - 1);
    cfg_sjw = 2'(jw - 1);
    bus_idle = idle;
    rx = rx0;
    n_clk = brp + 1;
    repeat (3) @(negedge clk);
    check(!bit_start_stb && !sample_stb && sample_bit, "R4", "reset outputs {start,sample,bit}",
          {29'd0, bit_start_stb, sample_stb, sample_bit}, 1);
    rst = 1'b0;
  endtask

  task automatic at_quantum(input int x);
    while (cyc < x * n_clk) @(negedge clk);
  endtask

  task automatic end_case(input int x, input string req);
    at_quantum(x);
    check(q.size() == 0, req, "strobes still outstanding", q.size(), 0);
    q.delete();
  endtask

  task automatic run_all();
    // R1 R2 R3: nominal timing, 9-quantum bit, 2 clocks per quantum
    start_case(1, 2, 3, 3, 2, 1'b0, 1'b1);
    push(1, 6, 1, "R3"); push(0, 9, 0, "R2"); push(1, 15, 1, "R3");
    push(0, 18, 0, "R2"); push(1, 24, 1, "R1"); push(0, 27, 0, "R1");
    end_case(28, "R2");

    // R5: late edge in first propagation quantum, stretch by 1
    start_case(1, 2, 3, 3, 2, 1'b0, 1'b1);
    push(1, 6, 1, "R3"); push(0, 9, 0, "R2"); push(1, 16, 0, "R5");
    push(0, 19, 0, "R5"); push(1, 25, 0, "R5"); push(0, 28, 0, "R5");
    at_quantum(10); rx = 1'b0;
    end_case(29, "R5");

    // R5: late edge 4 quanta after sync, clipped to jump width 2
    start_case(1, 2, 3, 3, 2, 1'b0, 1'b1);
    push(1, 6, 1, "R3"); push(0, 9, 0, "R2"); push(1, 17, 0, "R5");
    push(0, 20, 0, "R5"); push(1, 26, 0, "R5"); push(0, 29, 0, "R5");
    at_quantum(13); rx = 1'b0;
    end_case(30, "R5");

    // R6: early edge in first phase-2 quantum, bit cut short
    start_case(1, 2, 3, 3, 2, 1'b0, 1'b1);
    push(1, 6, 1, "R3"); push(0, 7, 0, "R6"); push(1, 13, 0, "R6"); push(0, 16, 0, "R6");
    at_quantum(6); rx = 1'b0;
    end_case(17, "R6");

    // R7: edge inside the sync quantum, no change
    start_case(1, 2, 3, 3, 2, 1'b0, 1'b1);
    push(1, 6, 1, "R3"); push(0, 9, 0, "R2"); push(1, 15, 0, "R7"); push(0, 18, 0, "R7");
    at_quantum(9); rx = 1'b0;
    end_case(19, "R7");

    // R8: second edge in the same bit ignored
    start_case(1, 2, 3, 3, 2, 1'b0, 1'b1);
    push(1, 6, 1, "R3"); push(0, 9, 0, "R2"); push(1, 16, 0, "R8"); push(0, 19, 0, "R8");
    at_quantum(10); rx = 1'b0;
    at_quantum(11); rx = 1'b1;
    at_quantum(12); rx = 1'b0;
    end_case(20, "R8");

    // R9: hard sync while idle, at the last phase-1 quantum
    start_case(1, 2, 3, 3, 2, 1'b1, 1'b1);
    push(1, 6, 1, "R3"); push(0, 9, 0, "R2"); push(1, 15, 1, "R3");
    push(0, 18, 0, "R2"); push(0, 24, 0, "R9"); push(1, 29, 0, "R9");
    at_quantum(23); rx = 1'b0;
    end_case(30, "R9");

    // R10: rising edge in propagation has no effect
    start_case(1, 2, 3, 3, 2, 1'b0, 1'b0);
    push(1, 6, 0, "R3"); push(0, 9, 0, "R2"); push(1, 15, 1, "R10"); push(0, 18, 0, "R10");
    at_quantum(10); rx = 1'b1;
    end_case(19, "R10");

    // R1 R2: 5 clocks per quantum, 6-quantum bit, dominant line
    start_case(4, 1, 2, 2, 4, 1'b0, 1'b0);
    push(1, 4, 0, "R1"); push(0, 6, 0, "R1"); push(1, 10, 0, "R2"); push(0, 12, 0, "R2");
    end_case(13, "R1");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    if (wd_hit) check(1'b0, "R2", "watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule